// File: doc/BRIEF.md
# Bus Wait-State Ready Generator

This block inserts wait states for a slow peripheral on an 8-bit processor bus. It watches the active-low, address-decoded select of the peripheral and a CPU clock phase input. The block runs on a fast system clock and treats the phase as a synchronous input. On every rising edge of the phase, a short shift register takes a sample of the select. When the newest sample shows the select active and an older sample, chosen by the parameter `WAIT_CYCLES`, shows it inactive, the block raises a wait request and pulls the CPU ready line low. The CPU sees ready low while the phase is high and repeats the bus cycle, so the access is stretched by `WAIT_CYCLES` bus cycles. Reads and writes are treated the same way, and the block has no direction input.

The plain clocked select is the decoded select gated with the high phase. During a stretched access it would go inactive in every low phase. The block therefore also drives a replacement select that stays active from the first high phase of the access to the end of its final high phase. The wait request itself comes from the shift-register taps. A small state machine drives ready and the replacement select. It has three states. ST_IDLE means no access is under way. ST_STRETCH means wait states are being inserted. ST_HELD means the select is still active but no more wait is owed.

The transitions are evaluated only on a rising phase edge. ST_IDLE goes to ST_STRETCH when the select is sampled active, and the wait counter is then loaded with `WAIT_CYCLES-1`. ST_STRETCH counts down while the select stays active. It goes to ST_HELD when the count is exhausted, or to ST_IDLE if the select is sampled inactive. ST_HELD goes to ST_IDLE when the select is sampled inactive. Synchronous reset returns the machine to ST_IDLE.

Top module: `wait_ready_gen`

## Requirements
- R1: While `rst_n` is low, all sample stages load the inactive value (1) at each clock edge. After release, `rdy_o` is 1 and `wait_req_o` is 0. `newsel_n_o` is 1 while the select is inactive.
- R2: The select is sampled only on a system clock edge where `phase_i` is 1 and was 0 at the previous edge. A select pulse that starts and ends between two such edges causes no wait.
- R3: `wait_req_o` is 1 exactly when the newest sample is 0 and the sample taken `WAIT_CYCLES` rising phase edges earlier is 1. It changes in the system clock cycle that follows the sampling edge.
- R4: For an access whose select stays active through the wait, `wait_req_o` stays 1 for exactly `WAIT_CYCLES` bus cycles, counted in rising phase edges. `WAIT_CYCLES` may be 1 or 2.
- R5: If the select stays active over many consecutive bus cycles, only one wait period is inserted, at the start of the run.
- R6: A new access that follows at least `WAIT_CYCLES` inactive samples gets its own full wait period.
- R7: `rdy_o` is always the inverse of `wait_req_o`. This holds for every access, whatever its direction.
- R8: `newsel_n_o` is 0 whenever the select is 0 and `phase_i` is 1. It is also 0 throughout a wait, including the low phases, so it never shows a gap within an access.
- R9: `newsel_n_o` is 1 whenever the select is 1 and no wait is active.
- R10: `rdy_o` changes only in the cycle after a sampling edge. It keeps its value across the low phase that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | CPU bus clock phase, synchronous to clk; high while the address is valid |
| sel_n_i | input | 1 | Active-low select, decoded from the address lines |
| rdy_o | output | 1 | CPU ready line; 0 holds the bus cycle |
| wait_req_o | output | 1 | Internal wait request decoded from the sample taps |
| newsel_n_o | output | 1 | Active-low replacement clocked select, continuous across a stretched access |

## Verification
The assertions assume the behaviour of a CPU that honours ready. Once the select is sampled active, it stays active at every sampling edge of the wait. The select and the phase change in the same system clock cycle only when the phase falls. Between two accesses, the select is sampled inactive at least `WAIT_CYCLES` times. Under those conditions the tap decode and the state machine agree. The bench drives each of its two instances (one and two wait cycles) with its own select. It keeps each access active for at least `WAIT_CYCLES+1` samples and leaves at least two idle bus cycles between accesses. Its only deliberate short pulse of the select falls inside a low phase.

// File: rtl/wait_ready_pkg.sv
package wait_ready_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_HELD    = 2'd2
    } access_state_e;

endpackage

// File: rtl/phase_edge_det.sv
module phase_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    output logic rise_o
);

    logic phase_q;

    // Reset to high so that a phase already high at release is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
        end else begin
            phase_q <= phase_i;
        end
    end

    always_comb begin
        rise_o = phase_i & ~phase_q;
    end

endmodule

// File: rtl/sel_tap_shift.sv
module sel_tap_shift #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_i,
    input  logic sel_n_i,
    output logic wait_req_o
);

    localparam int DEPTH = WAIT_CYCLES + 1;

    logic [DEPTH-1:0] taps_q;

    // Stage 0 takes the live select; each later stage takes its predecessor.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taps_q[g] <= 1'b1;
                end else if (shift_i) begin
                    if (g == 0) begin
                        taps_q[g] <= sel_n_i;
                    end else begin
                        taps_q[g] <= taps_q[(g > 0) ? g - 1 : 0];
                    end
                end
            end
        end
    endgenerate

    // Newest sample active, the chosen older sample inactive.
    always_comb begin
        wait_req_o = ~taps_q[0] & taps_q[DEPTH-1];
    end

endmodule

// File: rtl/ready_fsm.sv
module ready_fsm
    import wait_ready_pkg::*;
#(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic phase_i,
    input  logic sel_n_i,
    output logic rdy_o,
    output logic newsel_n_o
);

    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CYCLES - 1);

    access_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next state, evaluated only on a sampling edge.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rise_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!sel_n_i) begin
                        state_d = ST_STRETCH;
                        cnt_d   = CNT_LOAD;
                    end
                end
                ST_STRETCH: begin
                    if (sel_n_i) begin
                        state_d = ST_IDLE;
                    end else if (cnt_q == '0) begin
                        state_d = ST_HELD;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_HELD: begin
                    if (sel_n_i) begin
                        state_d = ST_IDLE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: the select is gated with the live phase, so it is already
    // active before the stretch state releases on the next edge.
    always_comb begin
        rdy_o      = 1'b1;
        newsel_n_o = ~(~sel_n_i & phase_i);
        unique case (state_q)
            ST_STRETCH: begin
                rdy_o      = 1'b0;
                newsel_n_o = 1'b0;
            end
            ST_IDLE, ST_HELD: begin
                rdy_o = 1'b1;
            end
            default: begin
                rdy_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wait_ready_gen.sv
module wait_ready_gen #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic sel_n_i,
    output logic rdy_o,
    output logic wait_req_o,
    output logic newsel_n_o
);

    logic phase_rise;

    phase_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_i),
        .rise_o  (phase_rise)
    );

    sel_tap_shift #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_taps (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (phase_rise),
        .sel_n_i    (sel_n_i),
        .wait_req_o (wait_req_o)
    );

    ready_fsm #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (phase_rise),
        .phase_i    (phase_i),
        .sel_n_i    (sel_n_i),
        .rdy_o      (rdy_o),
        .newsel_n_o (newsel_n_o)
    );

endmodule

// File: rtl/wait_ready_gen_chk.sv
module wait_ready_gen_chk #(
    parameter int WAIT_CYCLES = 1
) (
    input logic clk,
    input logic rst_n,
    input logic phase,
    input logic sel_n,
    input logic rdy,
    input logic wait_req,
    input logic newsel_n,
    input logic rise
);

    localparam int CW = $clog2(WAIT_CYCLES + 1) + 1;

    logic [CW-1:0] rises_in_wait;

    always_ff @(posedge clk) begin
        if (!rst_n || !wait_req) begin
            rises_in_wait <= '0;
        end else if (rise) begin
            rises_in_wait <= rises_in_wait + 1'b1;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (rdy && !wait_req));

    // R7
    ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy == !wait_req);

    // R10
    ready_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(rdy));

    // R4
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && rise) |-> (rises_in_wait < CW'(WAIT_CYCLES)));

    // R8
    sel_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |-> !newsel_n);

    // R8
    sel_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !sel_n) |=> !newsel_n);

    // R9
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !wait_req) |-> newsel_n);

    // R8
    sel_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && phase) |-> !newsel_n);

endmodule

bind wait_ready_gen wait_ready_gen_chk #(
    .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase_i),
    .sel_n    (sel_n_i),
    .rdy      (rdy_o),
    .wait_req (wait_req_o),
    .newsel_n (newsel_n_o),
    .rise     (phase_rise)
);

// File: tb/wait_ready_gen_tb.sv
module wait_ready_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W_A        = 1;
    localparam int W_B        = 2;
    localparam int LO_CLKS    = 3;
    localparam int HI_CLKS    = 3;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic  sa;
        logic  sb;
        logic  wa;
        logic  wb;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase = 1'b0;
    logic sel_a = 1'b1;
    logic sel_b = 1'b1;
    logic rdy_a, wait_a, ns_a;
    logic rdy_b, wait_b, ns_b;

    int   checks = 0;
    int   fails  = 0;
    exp_t q[$];
    exp_t cur;
    bit   have_cur = 1'b0;
    logic [7:0] hist_a = 8'hFF;
    logic [7:0] hist_b = 8'hFF;
    int   hi_n = 0;
    int   lo_n = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wait_ready_gen #(.WAIT_CYCLES(W_A)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .sel_n_i    (sel_a),
        .rdy_o      (rdy_a),
        .wait_req_o (wait_a),
        .newsel_n_o (ns_a)
    );

    wait_ready_gen #(.WAIT_CYCLES(W_B)) u_dut_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .sel_n_i    (sel_b),
        .rdy_o      (rdy_b),
        .wait_req_o (wait_b),
        .newsel_n_o (ns_b)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    endtask

    // Driver: one bus cycle (low phase, then high phase). The expected
    // wait per instance follows R3: newest sample 0, sample W ago 1.
    task automatic bus_cycle(input logic sa, input logic sb,
                             input bit glitch, input string tag);
        exp_t e;
        @(posedge clk); #1;
        phase = 1'b0;
        sel_a = sa;
        sel_b = sb;
        if (glitch) begin
            sel_a = 1'b0;
            sel_b = 1'b0;
            @(posedge clk); #1;
            sel_a = sa;
            sel_b = sb;
            repeat (LO_CLKS - 2) @(posedge clk);
        end else begin
            repeat (LO_CLKS - 1) @(posedge clk);
        end
        @(posedge clk); #1;
        hist_a = {hist_a[6:0], sa};
        hist_b = {hist_b[6:0], sb};
        e.sa  = sa;
        e.sb  = sb;
        e.wa  = !hist_a[0] && hist_a[W_A];
        e.wb  = !hist_b[0] && hist_b[W_B];
        e.tag = tag;
        q.push_back(e);
        phase = 1'b1;
        repeat (HI_CLKS - 1) @(posedge clk);
    endtask

    // Monitor: pops one item per rising phase and compares every half
    // period away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (phase) begin
                hi_n++;
                lo_n = 0;
                if (hi_n == 1) begin
                    if (q.size() == 0) begin
                        check("R2", "unexpected rising phase", 1'b1, 1'b0);
                    end else begin
                        cur      = q.pop_front();
                        have_cur = 1'b1;
                    end
                end
                if (have_cur) begin
                    // R8 / R9: select active across the whole high phase
                    check(cur.sa ? "R9" : "R8", "newsel A high phase", ns_a, cur.sa);
                    check(cur.sb ? "R9" : "R8", "newsel B high phase", ns_b, cur.sb);
                    if (hi_n >= 2) begin
                        check(cur.tag, "wait A", wait_a, cur.wa);
                        check(cur.tag, "wait B", wait_b, cur.wb);
                        check("R7", "ready A", rdy_a, !cur.wa);
                        check("R7", "ready B", rdy_b, !cur.wb);
                    end
                end
            end else begin
                lo_n++;
                hi_n = 0;
                if (have_cur) begin
                    // R10: ready holds through the low phase
                    check("R10", "ready A low phase", rdy_a, !cur.wa);
                    check("R10", "ready B low phase", rdy_b, !cur.wb);
                    check(cur.wa ? "R8" : "R9", "newsel A low phase", ns_a, !cur.wa);
                    check(cur.wb ? "R8" : "R9", "newsel B low phase", ns_b, !cur.wb);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        phase = 1'b0;
        sel_a = 1'b1;
        sel_b = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        check("R1", "ready A after reset", rdy_a, 1'b1);
        check("R1", "ready B after reset", rdy_b, 1'b1);
        check("R1", "wait A after reset", wait_a, 1'b0);
        check("R1", "wait B after reset", wait_b, 1'b0);
        check("R1", "newsel A after reset", ns_a, 1'b1);
        check("R1", "newsel B after reset", ns_b, 1'b1);

        for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b1, 1'b0, "R1");

        // R3 / R4: single access, A held 2 samples, B held 3
        bus_cycle(1'b0, 1'b0, 1'b0, "R3");
        bus_cycle(1'b0, 1'b0, 1'b0, "R4");
        bus_cycle(1'b1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b1, 1'b0, "R4");

        // R5: long run of back-to-back accesses
        for (int i = 0; i < 8; i++) bus_cycle(1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b1, 1'b0, "R5");

        // R6: two accesses separated by the minimum idle gap
        for (int j = 0; j < 2; j++) begin
            for (int i = 0; i < 3; i++) bus_cycle(1'b0, 1'b0, 1'b0, "R6");
            for (int i = 0; i < 2; i++) bus_cycle(1'b1, 1'b1, 1'b0, "R6");
        end

        // R2: select pulses inside the low phase only
        for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b1, 1'b1, "R2");

        // R4: a last access with staggered release
        bus_cycle(1'b0, 1'b0, 1'b0, "R4");
        bus_cycle(1'b0, 1'b0, 1'b0, "R4");
        bus_cycle(1'b0, 1'b0, 1'b0, "R4");
        bus_cycle(1'b1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 3; i++) bus_cycle(1'b1, 1'b1, 1'b0, "R4");

        @(posedge clk); #1 phase = 1'b0;
        repeat (4) @(posedge clk);
        summary();
    end

endmodule